// File: doc/BRIEF.md
# Access Violation Capture Unit

The unit sits behind a bus protection checker and receives the accesses that the checker has already rejected. Each rejected access arrives as a one-cycle report that carries the index of the slave module that was targeted, the ID of the requesting master, its security domain, the access direction and a 36-bit physical address. The unit sets one status bit per module and keeps a matching mask bit per module. It raises a level interrupt while any status bit is set whose mask bit is clear.

Modules are split into eight shift groups of 64 modules each, so the group of a module is its index divided by 64. The first violation to reach an idle group is stored as that group's record, and the group's bit in a shift status register becomes set. Software selects one group, starts a transfer, and waits for a done flag. The stored record is then visible in two debug registers. Software clears status, pending-group bits and the transfer control through its register port, or clears all violation state at once with one global bit.

The register port uses word indices, so the byte offset of a register is four times its index. Status words sit at indices 0 to 15 and mask words at indices 16 to 31. The remaining registers are the first debug register (32, byte 0x80), the second debug register (33), global control (34), shift status (35), shift select (36) and shift control (37). Writes take effect at the clock edge on which `reg_we` is high. Reads are combinational from the index.

Top module: `viol_capture`

## Requirements
- R1: After reset every status, mask, shift status, select, control and debug register reads 0 and `irq` is low. A report for module m sets bit m%32 of status word m/32, and leaves every other status bit as it was.
- R2: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: Mask words are plain read/write storage. A set mask bit keeps its module out of the interrupt, but a report for that module still sets the status bit.
- R4: `irq` is high in the cycle after any status bit with a clear mask bit becomes set. It stays high until no such bit remains.
- R5: A report for a module in group g (g = m/64) sets bit g of shift status (index 35). The record is stored only if that bit was clear, so a group keeps its first record. Later reports in the group still set their status bits.
- R6: Writing 1 to bit 0 of shift control (index 37) starts a transfer. Bit 0 reads back the last value written. Bit 1 (done) reads 1 from the second clock edge after the write edge, and stays 1 until shift control is written again.
- R7: When done sets and the select (index 36) is one-hot, the selected record is loaded into the debug registers. The first debug register holds master ID [15:0], domain ID [21:16], a write flag at [24], a read flag at [25] and address bits 35:32 at [31:28]. The second holds address bits 31:0.
- R8: A transfer started with an all-zero or non-one-hot select still sets done, and it leaves both debug registers unchanged.
- R9: Writing shift status clears exactly the group bits written as 1.
- R10: Writing 1 to bit 31 of global control (index 34) clears every status bit and every shift status bit. Mask, select, control and debug registers are not changed.
- R11: A report that arrives in the same cycle as a write that clears its status bit is kept, so the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A violation report is present this cycle |
| ev_module | input | 9 | Index of the slave module that was accessed |
| ev_master | input | 16 | ID of the requesting master |
| ev_domain | input | 6 | Security domain of the requester |
| ev_write | input | 1 | 1 for a write access, 0 for a read access |
| ev_addr | input | 36 | Physical address of the access |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 6 | Register word index (byte offset divided by 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` |
| irq | output | 1 | Level interrupt, any unmasked status bit set |

## Verification
The bench sends reports to the word and group boundaries (modules 0, 31, 32, 255, 479 and 510). A decoder that mixed up the word index and the bit offset would set the wrong status bit, and a wrong group split would raise the wrong shift status bit. The bench sends two reports to one group and checks that the first record survives; a design that overwrote records would show the second master. It times the done flag cycle by cycle, and it starts transfers with empty and two-hot selects; a design that loaded in those cases would change the debug registers. It sends a report and a clearing write for the same bit in the same cycle, where a design that let the clear win would lose the violation.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

  localparam int unsigned MASTER_W = 16;
  localparam int unsigned DOMAIN_W = 6;
  localparam int unsigned PA_W     = 36;

  typedef struct packed {
    logic [MASTER_W-1:0] master;
    logic [DOMAIN_W-1:0] domain;
    logic                is_write;
    logic [PA_W-1:0]     addr;
  } vcu_rec_t;

  // First debug word: addr high, read flag, write flag, domain, master.
  function automatic logic [31:0] dbg0_pack(input vcu_rec_t r);
    return {r.addr[PA_W-1:32], 2'b00, ~r.is_write, r.is_write, 2'b00,
            r.domain, r.master};
  endfunction

endpackage

// File: rtl/vcu_bitmap.sv
module vcu_bitmap #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned MOD_W     = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_valid,
  input  logic [MOD_W-1:0]              ev_module,
  input  logic                          sta_we,
  input  logic                          mask_we,
  input  logic [$clog2(NUM_WORDS)-1:0]  wsel,
  input  logic [31:0]                   wdata,
  input  logic                          gclr,
  output logic [NUM_WORDS-1:0][31:0]    sta_q,
  output logic [NUM_WORDS-1:0][31:0]    mask_q
);

  localparam int unsigned WSEL_W = $clog2(NUM_WORDS);
  localparam int unsigned HI_W   = MOD_W - 5;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] set_w, clr_w, sta_d, sta_r, mask_r;
    logic        sta_en, mask_en;

    always_comb begin
      set_w = '0;
      if (ev_valid && (ev_module[MOD_W-1:5] == HI_W'(w)))
        set_w = 32'd1 << ev_module[4:0];
      clr_w = '0;
      if (gclr)
        clr_w = '1;
      else if (sta_we && (wsel == WSEL_W'(w)))
        clr_w = wdata;
      // a new violation outranks any clear in the same cycle
      sta_d   = (sta_r & ~clr_w) | set_w;
      sta_en  = (|set_w) || (|clr_w);
      mask_en = mask_we && (wsel == WSEL_W'(w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sta_r  <= '0;
        mask_r <= '0;
      end else begin
        if (sta_en)  sta_r  <= sta_d;
        if (mask_en) mask_r <= wdata;
      end
    end

    assign sta_q[w]  = sta_r;
    assign mask_q[w] = mask_r;
  end

endmodule

// File: rtl/vcu_group_store.sv
module vcu_group_store
  import vcu_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned GRP_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  input  logic [GRP_W-1:0]      ev_group,
  input  vcu_rec_t              ev_rec,
  input  logic                  pend_we,
  input  logic [NUM_GROUPS-1:0] pend_wdata,
  input  logic                  gclr,
  input  logic [NUM_GROUPS-1:0] sel,
  output logic [NUM_GROUPS-1:0] pend_q,
  output vcu_rec_t              sel_rec
);

  vcu_rec_t              rec_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] set_v, clr_v, cap_v, pend_d;
  logic                  pend_en;

  always_comb begin
    clr_v = gclr ? '1 : (pend_we ? pend_wdata : '0);
    set_v = '0;
    if (ev_valid) set_v[ev_group] = 1'b1;
    // capture only into a group that is idle after this cycle's clears
    cap_v   = set_v & (~pend_q | clr_v);
    pend_d  = (pend_q & ~clr_v) | set_v;
    pend_en = (|set_v) || (|clr_v);
  end

  always_comb begin
    sel_rec = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (sel[g]) sel_rec = sel_rec | rec_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) rec_q[g] <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      for (int g = 0; g < NUM_GROUPS; g++)
        if (cap_v[g]) rec_q[g] <= ev_rec;
    end
  end

endmodule

// File: rtl/vcu_shift_seq.sv
module vcu_shift_seq
  import vcu_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_we,
  input  logic [NUM_GROUPS-1:0] sel_wdata,
  input  logic                  ctl_we,
  input  logic                  ctl_wstart,
  input  vcu_rec_t              sel_rec,
  output logic [NUM_GROUPS-1:0] sel_q,
  output logic                  start_q,
  output logic                  done_q,
  output logic [31:0]           dbg0_q,
  output logic [31:0]           dbg1_q
);

  logic go1_q, go2_q, go1_d, go2_d, done_d, sel_ok, load_en;

  always_comb begin
    sel_ok  = (sel_q != '0) && ((sel_q & (sel_q - 1'b1)) == '0);
    // any control write restarts the two-stage delay
    go1_d   = ctl_we && ctl_wstart;
    go2_d   = ctl_we ? 1'b0 : go1_q;
    done_d  = ctl_we ? 1'b0 : (go2_q || done_q);
    load_en = go2_q && !ctl_we && sel_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      start_q <= 1'b0;
      go1_q   <= 1'b0;
      go2_q   <= 1'b0;
      done_q  <= 1'b0;
      dbg0_q  <= '0;
      dbg1_q  <= '0;
    end else begin
      go1_q  <= go1_d;
      go2_q  <= go2_d;
      done_q <= done_d;
      if (sel_we) sel_q   <= sel_wdata;
      if (ctl_we) start_q <= ctl_wstart;
      if (load_en) begin
        dbg0_q <= dbg0_pack(sel_rec);
        dbg1_q <= sel_rec.addr[31:0];
      end
    end
  end

endmodule

// File: rtl/viol_capture.sv
module viol_capture
  import vcu_pkg::*;
#(
  parameter int unsigned NUM_MODULES = 512,
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned REG_AW      = $clog2(2 * (NUM_MODULES / 32) + 6)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_valid,
  input  logic [$clog2(NUM_MODULES)-1:0] ev_module,
  input  logic [MASTER_W-1:0]         ev_master,
  input  logic [DOMAIN_W-1:0]         ev_domain,
  input  logic                        ev_write,
  input  logic [PA_W-1:0]             ev_addr,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_word,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        irq
);

  localparam int unsigned MOD_W     = $clog2(NUM_MODULES);
  localparam int unsigned NUM_WORDS = NUM_MODULES / 32;
  localparam int unsigned WSEL_W    = $clog2(NUM_WORDS);
  localparam int unsigned GRP_W     = $clog2(NUM_GROUPS);
  localparam int unsigned W_DBG0    = 2 * NUM_WORDS;
  localparam int unsigned W_DBG1    = W_DBG0 + 1;
  localparam int unsigned W_GCTL    = W_DBG0 + 2;
  localparam int unsigned W_PEND    = W_DBG0 + 3;
  localparam int unsigned W_SEL     = W_DBG0 + 4;
  localparam int unsigned W_CTL     = W_DBG0 + 5;

  logic [NUM_WORDS-1:0][31:0] sta_q, mask_q;
  logic [NUM_GROUPS-1:0]      pend_q, sel_q;
  logic                       start_q, done_q;
  logic [31:0]                dbg0_q, dbg1_q;
  logic                       sta_we, mask_we, pend_we, sel_we, ctl_we, gclr;
  vcu_rec_t                   ev_rec, sel_rec;

  always_comb begin
    sta_we  = reg_we && (reg_word < REG_AW'(NUM_WORDS));
    mask_we = reg_we && !sta_we && (reg_word < REG_AW'(W_DBG0));
    pend_we = reg_we && (reg_word == REG_AW'(W_PEND));
    sel_we  = reg_we && (reg_word == REG_AW'(W_SEL));
    ctl_we  = reg_we && (reg_word == REG_AW'(W_CTL));
    gclr    = reg_we && (reg_word == REG_AW'(W_GCTL)) && reg_wdata[31];
    ev_rec  = '{master: ev_master, domain: ev_domain,
                is_write: ev_write, addr: ev_addr};
  end

  vcu_bitmap #(.NUM_WORDS(NUM_WORDS), .MOD_W(MOD_W)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_module(ev_module),
    .sta_we(sta_we), .mask_we(mask_we), .wsel(reg_word[WSEL_W-1:0]),
    .wdata(reg_wdata), .gclr(gclr), .sta_q(sta_q), .mask_q(mask_q)
  );

  vcu_group_store #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_groups (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
    .ev_group(ev_module[MOD_W-1:MOD_W-GRP_W]), .ev_rec(ev_rec),
    .pend_we(pend_we), .pend_wdata(reg_wdata[NUM_GROUPS-1:0]), .gclr(gclr),
    .sel(sel_q), .pend_q(pend_q), .sel_rec(sel_rec)
  );

  vcu_shift_seq #(.NUM_GROUPS(NUM_GROUPS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we),
    .sel_wdata(reg_wdata[NUM_GROUPS-1:0]), .ctl_we(ctl_we),
    .ctl_wstart(reg_wdata[0]), .sel_rec(sel_rec), .sel_q(sel_q),
    .start_q(start_q), .done_q(done_q), .dbg0_q(dbg0_q), .dbg1_q(dbg1_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_word < REG_AW'(NUM_WORDS))
      reg_rdata = sta_q[reg_word[WSEL_W-1:0]];
    else if (reg_word < REG_AW'(W_DBG0))
      reg_rdata = mask_q[reg_word[WSEL_W-1:0]];
    else if (reg_word == REG_AW'(W_DBG0)) reg_rdata = dbg0_q;
    else if (reg_word == REG_AW'(W_DBG1)) reg_rdata = dbg1_q;
    else if (reg_word == REG_AW'(W_PEND)) reg_rdata = 32'(pend_q);
    else if (reg_word == REG_AW'(W_SEL))  reg_rdata = 32'(sel_q);
    else if (reg_word == REG_AW'(W_CTL))  reg_rdata = {30'd0, done_q, start_q};
  end

  assign irq = |(sta_q & ~mask_q);

endmodule

// File: rtl/vcu_checker.sv
module vcu_checker #(
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned MOD_W      = 9,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned REG_AW     = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ev_valid,
  input logic [MOD_W-1:0]           ev_module,
  input logic                       reg_we,
  input logic [REG_AW-1:0]          reg_word,
  input logic                       wr_bit0,
  input logic                       wr_bit31,
  input logic                       irq,
  input logic [NUM_WORDS-1:0][31:0] mask_bits,
  input logic [NUM_GROUPS-1:0]      pend,
  input logic                       done
);

  localparam int unsigned W_GCTL = 2 * NUM_WORDS + 2;
  localparam int unsigned W_CTL  = 2 * NUM_WORDS + 5;

  logic start_wr, ctl_wr, gclr_wr, ev_unmasked;

  always_comb begin
    ctl_wr      = reg_we && (reg_word == REG_AW'(W_CTL));
    start_wr    = ctl_wr && wr_bit0;
    gclr_wr     = reg_we && (reg_word == REG_AW'(W_GCTL)) && wr_bit31;
    ev_unmasked = !mask_bits[ev_module[MOD_W-1:5]][ev_module[4:0]];
  end

  p_irq_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !reg_we && ev_unmasked) |=> irq);

  p_done_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start_wr, 3));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_wr) |=> done);

  p_gclr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gclr_wr && !ev_valid) |=> !irq);

  p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((pend & $past(pend)) == $past(pend)));

endmodule

bind viol_capture vcu_checker #(
  .NUM_WORDS(NUM_WORDS), .MOD_W(MOD_W), .NUM_GROUPS(NUM_GROUPS), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_module(ev_module),
  .reg_we(reg_we), .reg_word(reg_word), .wr_bit0(reg_wdata[0]),
  .wr_bit31(reg_wdata[31]), .irq(irq), .mask_bits(mask_q), .pend(pend_q),
  .done(done_q)
);

// File: tb/viol_capture_bench.sv
module viol_capture_bench;

  localparam int W_DBG0 = 32, W_DBG1 = 33, W_GCTL = 34;
  localparam int W_PEND = 35, W_SEL = 36, W_CTL = 37, W_MASK = 16;

  typedef struct packed {
    logic [8:0]  m;
    logic [15:0] mas;
    logic [5:0]  dom;
    logic        wr;
    logic [35:0] pa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{9'd0,   16'h1234, 6'h05, 1'b1, 36'h3_1000_0000},
    '{9'd31,  16'hBEEF, 6'h3F, 1'b0, 36'hF_FFFF_FFFC},
    '{9'd32,  16'h0001, 6'h00, 1'b1, 36'h0_0000_0040},
    '{9'd100, 16'h7A7A, 6'h11, 1'b0, 36'h5_DEAD_BEEF},
    '{9'd255, 16'hFFFF, 6'h2A, 1'b1, 36'h8_9ABC_DEF0},
    '{9'd300, 16'h0042, 6'h01, 1'b0, 36'hA_0000_0000},
    '{9'd479, 16'h5555, 6'h15, 1'b1, 36'h2_8000_0001},
    '{9'd510, 16'hA5A5, 6'h2C, 1'b0, 36'hC_CAFE_F00D}
  };

  logic        clk, rst_n, ev_valid, ev_write, reg_we, irq;
  logic [8:0]  ev_module;
  logic [15:0] ev_master;
  logic [5:0]  ev_domain, reg_word;
  logic [35:0] ev_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int          n_chk, n_bad;

  viol_capture u_viol_capture (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_module(ev_module),
    .ev_master(ev_master), .ev_domain(ev_domain), .ev_write(ev_write),
    .ev_addr(ev_addr), .reg_we(reg_we), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] exp_dbg0(input vec_t v);
    return {v.pa[35:32], 2'b00, ~v.wr, v.wr, 2'b00, v.dom, v.mas};
  endfunction

  function automatic vec_t mk(input int m, input logic [15:0] mas);
    vec_t v;
    v = '{9'(m), mas, 6'h09, 1'b1, 36'h1_0000_0100 + 36'(m)};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_word = 6'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input int idx, input logic [31:0] exp);
    reg_word = 6'(idx);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic drive_ev(input vec_t v);
    ev_valid = 1'b1; ev_module = v.m; ev_master = v.mas;
    ev_domain = v.dom; ev_write = v.wr; ev_addr = v.pa;
  endtask

  task automatic fire(input vec_t v);
    @(negedge clk);
    drive_ev(v);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic shift(input int g);
    wr(W_SEL, 32'd1 << g);
    wr(W_CTL, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ev_valid = 1'b0; ev_module = '0; ev_master = '0;
    ev_domain = '0; ev_write = 1'b0; ev_addr = '0;
    reg_we = 1'b0; reg_word = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rchk("R1 status word 0", 0, 32'd0);
    rchk("R1 status word 15", 15, 32'd0);
    rchk("R1 mask word 0", W_MASK, 32'd0);
    rchk("R1 shift status", W_PEND, 32'd0);
    rchk("R1 shift control", W_CTL, 32'd0);
    rchk("R1 debug 0", W_DBG0, 32'd0);

    // vector table: report, observe, transfer, clean up
    for (int i = 0; i < NV; i++) begin
      int w, b, g;
      w = int'(VEC[i].m) / 32; b = int'(VEC[i].m) % 32; g = int'(VEC[i].m) / 64;
      fire(VEC[i]);
      rchk("R1 status bit set", w, 32'd1 << b);
      chk("R4 irq raised", 32'(irq), 32'd1);
      rchk("R5 group pending", W_PEND, 32'd1 << g);
      shift(g);
      rchk("R6 start and done", W_CTL, 32'd3);
      rchk("R7 debug 0 packing", W_DBG0, exp_dbg0(VEC[i]));
      rchk("R7 debug 1 address", W_DBG1, VEC[i].pa[31:0]);
      wr(W_CTL, 32'd0);
      rchk("R6 done cleared by write", W_CTL, 32'd0);
      wr(W_SEL, 32'd0);
      wr(W_PEND, 32'd1 << g);
      rchk("R9 pending cleared", W_PEND, 32'd0);
      wr(w, 32'd1 << b);
      rchk("R2 status cleared", w, 32'd0);
      chk("R4 irq dropped", 32'(irq), 32'd0);
    end

    // R2 zero writes keep bits
    fire(mk(40, 16'h0040));
    wr(1, 32'd0);
    rchk("R2 zero write keeps", 1, 32'h0000_0100);
    wr(1, 32'h0000_0001);
    rchk("R2 other bit write keeps", 1, 32'h0000_0100);

    // R3 mask
    wr(W_MASK + 1, 32'h0000_0100);
    rchk("R3 mask readback", W_MASK + 1, 32'h0000_0100);
    chk("R3 masked irq low", 32'(irq), 32'd0);
    fire(mk(41, 16'h0041));
    wr(W_MASK + 1, 32'h0000_0300);
    rchk("R3 masked status still set", 1, 32'h0000_0300);
    chk("R3 all masked irq low", 32'(irq), 32'd0);
    wr(W_MASK + 1, 32'h0000_0200);
    chk("R4 unmask raises irq", 32'(irq), 32'd1);
    wr(W_MASK + 1, 32'd0);
    wr(W_GCTL, 32'h8000_0000);

    // R5 first record kept
    fire(mk(70, 16'hAAAA));
    fire(mk(80, 16'hBBBB));
    rchk("R5 both status bits", 2, (32'd1 << 6) | (32'd1 << 16));
    shift(1);
    rchk("R5 first record kept", W_DBG0, exp_dbg0(mk(70, 16'hAAAA)));
    wr(W_CTL, 32'd0);

    // R8 empty and two-hot selects
    wr(W_SEL, 32'd0);
    wr(W_CTL, 32'd1);
    repeat (2) @(negedge clk);
    rchk("R8 empty select done", W_CTL, 32'd3);
    rchk("R8 empty select no load", W_DBG0, exp_dbg0(mk(70, 16'hAAAA)));
    wr(W_CTL, 32'd0);
    wr(W_SEL, 32'h0000_0003);
    wr(W_CTL, 32'd1);
    repeat (2) @(negedge clk);
    rchk("R8 two-hot select done", W_CTL, 32'd3);
    rchk("R8 two-hot select no load", W_DBG1, mk(70, 16'hAAAA).pa[31:0]);
    wr(W_CTL, 32'd0);

    // R6 done latency and hold
    wr(W_SEL, 32'd2);
    wr(W_CTL, 32'd1);
    rchk("R6 done low after write edge", W_CTL, 32'd1);
    @(negedge clk);
    rchk("R6 done low one edge later", W_CTL, 32'd1);
    @(negedge clk);
    rchk("R6 done high two edges later", W_CTL, 32'd3);
    repeat (5) @(negedge clk);
    rchk("R6 done holds", W_CTL, 32'd3);
    wr(W_CTL, 32'd0);
    wr(W_SEL, 32'd0);

    // R10 global clear
    fire(mk(5, 16'h0005));
    fire(mk(400, 16'h0400));
    wr(W_GCTL, 32'h8000_0000);
    rchk("R10 status word 0 cleared", 0, 32'd0);
    rchk("R10 status word 12 cleared", 12, 32'd0);
    rchk("R10 pending cleared", W_PEND, 32'd0);
    chk("R10 irq low", 32'(irq), 32'd0);
    rchk("R10 debug kept", W_DBG0, exp_dbg0(mk(70, 16'hAAAA)));

    // R11 report and clear in the same cycle
    @(negedge clk);
    drive_ev(mk(7, 16'h0007));
    reg_we = 1'b1; reg_word = 6'd0; reg_wdata = 32'd1 << 7;
    @(negedge clk);
    ev_valid = 1'b0; reg_we = 1'b0;
    rchk("R11 report beats clear", 0, 32'd1 << 7);
    chk("R11 irq high", 32'(irq), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule